// File: doc/BRIEF.md
# UART Transmit Path with Byte Queue

This block is the transmit half of a classic 16550-class serial port. Software writes bytes to a holding register. With queueing enabled, each byte goes into a 16-entry first-in first-out store. With queueing disabled, a single holding register keeps one byte. The block moves bytes one at a time into a shift register. The shift register sends each byte as an asynchronous frame: one low start bit, eight data bits with the least significant bit first, and one high stop bit. The frame advances one bit per pulse of an external baud enable.

The block keeps two line-status flags. `thre` shows that the holding side is empty. `temt` shows that both the holding side and the shifter are empty. When `thre` becomes set, the block sends a single-cycle request to the interrupt logic. It does not send another request until that one is acknowledged. In loopback mode the line stays high, and each finished byte is handed to the receive side on a separate output.

The `queue_en` and `loopback` inputs are only changed while both flags are set.

Top module: `uart_tx_path`

## Requirements
- R1: After synchronous reset the line `txd` is high, `thre` and `temt` are 1, and `thre_irq` and `lb_valid` are 0.
- R2: A write (`wr_en` high for one cycle) makes `thre` and `temt` read 0 in the following cycle, whatever the mode.
- R3: Each byte leaves as a frame: start bit 0, eight data bits with bit 0 first, then stop bit 1. Each bit ends on a cycle where `baud_tick` is high. `txd` is 1 between frames.
- R4: With `queue_en`=1, queued bytes leave in write order. Each new frame starts right after the previous stop bit, with no idle bit time between frames.
- R5: With `queue_en`=1 the queue holds 16 bytes. A write to a full queue first discards the oldest queued byte, then stores the new byte.
- R6: With `queue_en`=1, `thre` stays 0 while any byte is queued. It becomes 1 only when the shifter takes the last queued byte.
- R7: With `queue_en`=0, an idle shifter takes the holding byte on the cycle after the write, and `thre` becomes 1 at that load. While the shifter is busy, the byte stays in the holding register with `thre`=0, and a newer write replaces it.
- R8: `temt` becomes 1 only after the final stop bit has been sent and `thre` is 1. It stays 0 while a frame is in progress.
- R9: A 0-to-1 change of `thre` produces a one-cycle `thre_irq` pulse, but only when no earlier pulse is still pending. A `thre_ack` pulse clears the pending state.
- R10: With `loopback`=1, `txd` stays 1. At the end of each frame, `lb_valid` pulses for one cycle with the byte on `lb_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte written |
| queue_en | input | 1 | 1 selects queued mode, 0 selects single holding register |
| loopback | input | 1 | 1 routes finished bytes to `lb_data` instead of the line |
| baud_tick | input | 1 | One-cycle enable that ends the current bit |
| thre_ack | input | 1 | Clears the pending holding-empty request |
| txd | output | 1 | Serial line, idle high |
| thre | output | 1 | Holding side empty |
| temt | output | 1 | Holding side and shifter both empty |
| thre_irq | output | 1 | One-cycle request when `thre` becomes set |
| lb_valid | output | 1 | Loopback byte strobe |
| lb_data | output | 8 | Loopback byte |

## Verification
Most internal faults show up at the ports within one frame time. A wrong queue pointer or a bad discard-on-full rule delivers the wrong byte in order, and the scoreboard flags it at the stop bit of that frame. A wrong `thre` or `temt` update is visible one cycle after the write or load that caused it. It also makes the next byte load too early or too late, which changes either the frame contents or the spacing between frames. A missed or extra `thre_irq` pulse is counted against the number of `thre` rises expected in each phase.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_SEND = 1'b1
  } sh_state_e;

  function automatic int frame_bits(input int data_w);
    return data_w + 2;
  endfunction

endpackage

// File: rtl/uart_tx_queue.sv
module uart_tx_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic                         pop,
  input  logic [DATA_W-1:0]            din,
  output logic [DATA_W-1:0]            dout,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full;
  logic              drop;

  function automatic logic [PTR_W-1:0] inc_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CNT_FULL);
  assign drop  = push && full && !pop;
  assign dout  = mem[rd_ptr_q];
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= inc_ptr(wr_ptr_q);
      if (pop || drop) rd_ptr_q <= inc_ptr(rd_ptr_q);
      if (push && !pop && !full) cnt_q <= cnt_q + 1'b1;
      else if (pop && !push)     cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_FULL);                                          // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> cnt_q != '0);                                        // R6
  AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> full);                                    // R5

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              loopback,
  input  logic              baud_tick,
  output logic              busy,
  output logic              done,
  output logic              txd,
  output logic              lb_valid,
  output logic [DATA_W-1:0] lb_data
);
  localparam int FRAME_W = frame_bits(DATA_W);
  localparam int BCNT_W  = $clog2(FRAME_W);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(FRAME_W - 1);

  sh_state_e         state_q;
  logic [DATA_W:0]   shreg_q;
  logic [DATA_W-1:0] byte_q;
  logic [BCNT_W-1:0] bit_q;

  assign busy = (state_q == SH_SEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SH_IDLE;
      shreg_q  <= '1;
      byte_q   <= '0;
      bit_q    <= '0;
      txd      <= 1'b1;
      done     <= 1'b0;
      lb_valid <= 1'b0;
      lb_data  <= '0;
    end else begin
      done     <= 1'b0;
      lb_valid <= 1'b0;
      if (load) begin
        state_q <= SH_SEND;
        shreg_q <= {1'b1, load_data};
        byte_q  <= load_data;
        bit_q   <= '0;
        txd     <= loopback;
      end else if (busy && baud_tick) begin
        if (bit_q == LAST_BIT) begin
          state_q <= SH_IDLE;
          done    <= 1'b1;
          txd     <= 1'b1;
          if (loopback) begin
            lb_valid <= 1'b1;
            lb_data  <= byte_q;
          end
        end else begin
          txd     <= loopback | shreg_q[0];
          shreg_q <= {1'b1, shreg_q[DATA_W:1]};
          bit_q   <= bit_q + 1'b1;
        end
      end
    end
  end

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);                                             // R7
  AST_LB_AT_FRAME_END: assert property (@(posedge clk) disable iff (rst)
    lb_valid |-> done);                                          // R10
  AST_LINE_HIGH_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load) |=> txd);                                   // R3

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              queue_en,
  input  logic              loopback,
  input  logic              baud_tick,
  input  logic              thre_ack,
  output logic              txd,
  output logic              thre,
  output logic              temt,
  output logic              thre_irq,
  output logic              lb_valid,
  output logic [DATA_W-1:0] lb_data
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic              thre_q, temt_q, pend_q, irq_q;
  logic [DATA_W-1:0] hold_q;
  logic              sh_busy, sh_done, load;
  logic [DATA_W-1:0] q_dout, load_byte;
  logic [CNT_W-1:0]  q_count;
  logic              thre_nxt, thre_rise;

  assign load      = !sh_busy && !thre_q;
  assign load_byte = queue_en ? q_dout : hold_q;

  uart_tx_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
    .clk   (clk),
    .rst   (rst),
    .push  (wr_en && queue_en),
    .pop   (load && queue_en),
    .din   (wr_data),
    .dout  (q_dout),
    .count (q_count)
  );

  uart_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_data (load_byte),
    .loopback  (loopback),
    .baud_tick (baud_tick),
    .busy      (sh_busy),
    .done      (sh_done),
    .txd       (txd),
    .lb_valid  (lb_valid),
    .lb_data   (lb_data)
  );

  always_comb begin
    thre_nxt = thre_q;
    if (wr_en)     thre_nxt = 1'b0;
    else if (load) thre_nxt = queue_en ? (q_count == CNT_W'(1)) : 1'b1;
  end

  assign thre_rise = thre_nxt && !thre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      thre_q <= 1'b1;
      temt_q <= 1'b1;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      thre_q <= thre_nxt;
      if (wr_en)                  temt_q <= 1'b0;
      else if (sh_done && thre_q) temt_q <= 1'b1;
      if (wr_en && !queue_en) hold_q <= wr_data;
      irq_q <= thre_rise && (!pend_q || thre_ack);
      if (thre_rise)     pend_q <= 1'b1;
      else if (thre_ack) pend_q <= 1'b0;
    end
  end

  assign thre     = thre_q;
  assign temt     = temt_q;
  assign thre_irq = irq_q;

  AST_WRITE_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (!thre && !temt));                                 // R2
  AST_TEMT_NEEDS_THRE: assert property (@(posedge clk) disable iff (rst)
    temt |-> thre);                                              // R8
  AST_TEMT_SHIFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
    temt |-> !sh_busy);                                          // R8
  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    thre_irq |-> (thre && !$past(thre)));                        // R9
  AST_THRE_TRACKS_QUEUE: assert property (@(posedge clk) disable iff (rst)
    (queue_en && $past(queue_en) && !$past(wr_en)) |-> (thre == (q_count == '0))); // R6

endmodule

// File: tb/uart_tx_path_tb.sv
`timescale 1ns/1ps
module uart_tx_path_tb;
  localparam int DW       = 8;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst, wr_en, queue_en, loopback, baud_tick, thre_ack;
  logic [DW-1:0] wr_data;
  logic          txd, thre, temt, thre_irq, lb_valid;
  logic [DW-1:0] lb_data;

  uart_tx_path #(.DATA_W(DW), .DEPTH(16)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .queue_en(queue_en), .loopback(loopback), .baud_tick(baud_tick),
    .thre_ack(thre_ack), .txd(txd), .thre(thre), .temt(temt),
    .thre_irq(thre_irq), .lb_valid(lb_valid), .lb_data(lb_data)
  );

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] exp_q[$];
  int mon_bit = -1;
  logic [DW-1:0] mon_byte;
  int gap = 0, gap_err = 0, irq_cnt = 0, lb_low = 0;
  bit burst_mode = 0, burst_first = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic take(input logic [DW-1:0] b, input string req);
    if (exp_q.size() == 0) chk(1'b0, {req, " unexpected byte"}, b, -1);
    else begin
      logic [DW-1:0] e;
      e = exp_q.pop_front();
      chk(b == e, {req, " byte order/value"}, b, e);
    end
  endtask

  // baud enable generator
  initial begin
    baud_tick = 1'b0;
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  // monitor: decodes the line and the loopback port, compares against the queue
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (thre_irq) irq_cnt++;
        if (loopback && !txd) lb_low++;
        if (lb_valid) take(lb_data, "R10");
        if (baud_tick) begin
          if (mon_bit < 0) begin
            if (!txd) begin
              if (burst_mode) begin
                if (burst_first) burst_first = 0;
                else if (gap > 0) gap_err++;
              end
              mon_bit = 0;
            end else gap++;
          end else if (mon_bit < DW) begin
            mon_byte[mon_bit] = txd;
            mon_bit++;
          end else begin
            chk(txd == 1'b1, "R3 stop bit", txd, 1);
            take(mon_byte, "R3");
            mon_bit = -1;
            gap = 0;
          end
        end
      end
    end
  end

  task automatic wr(input logic [DW-1:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ack();
    thre_ack = 1'b1;
    @(negedge clk);
    thre_ack = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(thre && temt && mon_bit < 0));
    repeat (2) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
    $finish;
  end

  initial begin
    int irq_before;
    rst = 1'b1; wr_en = 1'b0; wr_data = '0; queue_en = 1'b0;
    loopback = 1'b0; thre_ack = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(thre == 1'b1 && temt == 1'b1, "R1 flags", {thre, temt}, 3);
    chk(thre_irq == 1'b0 && lb_valid == 1'b0, "R1 strobes", {thre_irq, lb_valid}, 0);

    // single byte, holding-register mode
    exp_q.push_back(8'hA5);
    wr(8'hA5);
    chk(thre == 1'b0 && temt == 1'b0, "R2 flags after write", {thre, temt}, 0);
    @(negedge clk);
    chk(thre == 1'b1, "R7 thre set at load", thre, 1);
    chk(temt == 1'b0, "R8 temt clear while sending", temt, 0);
    wait_idle();
    chk(exp_q.size() == 0, "R3 all bytes seen", exp_q.size(), 0);
    chk(irq_cnt == 1, "R9 first pulse", irq_cnt, 1);
    chk(temt == 1'b1, "R8 temt after stop", temt, 1);

    // pending request blocks a second pulse until acknowledged
    exp_q.push_back(8'h3C);
    wr(8'h3C);
    wait_idle();
    chk(irq_cnt == 1, "R9 no pulse while pending", irq_cnt, 1);
    ack();
    exp_q.push_back(8'h5A);
    wr(8'h5A);
    wait_idle();
    chk(irq_cnt == 2, "R9 pulse after ack", irq_cnt, 2);

    // holding register overwritten while shifter busy
    exp_q.push_back(8'h11);
    exp_q.push_back(8'h33);
    wr(8'h11);
    repeat (3) @(negedge clk);
    wr(8'h22);
    wr(8'h33);
    chk(thre == 1'b0, "R7 holding full while busy", thre, 0);
    wait_idle();
    chk(exp_q.size() == 0, "R7 newest write kept", exp_q.size(), 0);

    // queued burst, back to back
    queue_en = 1'b1;
    ack();
    irq_before = irq_cnt;
    burst_mode = 1; burst_first = 1; gap_err = 0;
    for (int i = 0; i < 5; i++) begin
      exp_q.push_back(8'(8'h40 + i * 7));
      wr(8'(8'h40 + i * 7));
    end
    repeat (60) @(negedge clk);
    chk(thre == 1'b0, "R6 thre clear while queued", thre, 0);
    chk(temt == 1'b0, "R8 temt clear mid burst", temt, 0);
    wait_idle();
    burst_mode = 0;
    chk(gap_err == 0, "R4 frames back to back", gap_err, 0);
    chk(exp_q.size() == 0, "R4 burst order", exp_q.size(), 0);
    chk(irq_cnt == irq_before + 1, "R6 one thre rise per burst", irq_cnt, irq_before + 1);

    // overflow: 18 writes, first goes to shifter, byte 1 is discarded
    exp_q.push_back(8'h80);
    for (int i = 2; i < 18; i++) exp_q.push_back(8'(8'h80 + i));
    for (int i = 0; i < 18; i++) wr(8'(8'h80 + i));
    wait_idle();
    chk(exp_q.size() == 0, "R5 oldest dropped on full", exp_q.size(), 0);

    // loopback
    loopback = 1'b1;
    lb_low = 0;
    exp_q.push_back(8'hC3);
    exp_q.push_back(8'h96);
    wr(8'hC3);
    wr(8'h96);
    wait_idle();
    chk(lb_low == 0, "R10 line held high", lb_low, 0);
    chk(exp_q.size() == 0, "R10 bytes returned", exp_q.size(), 0);
    loopback = 1'b0;

    report();
    $finish;
  end

endmodule